// File: doc/BRIEF.md
# Auto-Increment Indirect Memory and Peripheral Window

This block lets a host reach an internal word-addressed SRAM and an internal peripheral register space through eight registers on a simple request/acknowledge register bus. For memory, the host loads a read pointer or a write pointer with a full 32-bit byte address. Each later access to the matching data register moves one 32-bit word and advances that pointer by four bytes. A burst of data-register accesses therefore walks through consecutive words without the host reloading the address.

The peripheral side uses its own pair of address registers. Each holds a register offset in the low bits and a two-bit length code in bits 25..24 that gives the number of bytes minus one. Peripheral data accesses never move the offset. Writes drive byte enables for the low bytes only, and reads zero the bytes above the length. The SRAM and the peripheral ports both return read data one cycle after their enable.

Register indices on `hostReg`: 0 memory read pointer, 1 memory write pointer, 2 memory write data, 3 memory read data, 4 peripheral read address, 5 peripheral write address, 6 peripheral write data, 7 peripheral read data.

Top module: `indirect_window`

## Requirements
- R1: After reset both memory pointers and both peripheral address registers read zero, and `hostAck`, `memEn` and `perEn` are low.
- R2: A request accepted while the block is idle is acknowledged by a one-cycle `hostAck` pulse in the next cycle, and `hostRdata` is valid in that cycle. The host drops `hostReq` after the pulse.
- R3: Writing register 0 or 1 loads all 32 bits of the memory read or write pointer. Reading either register returns its current value, including increments already applied.
- R4: Writing register 2 writes `hostWdata` to SRAM word `wptr[MEM_AW+1:2]` and then adds 4 to the write pointer.
- R5: Reading register 3 returns the SRAM word at `rptr[MEM_AW+1:2]` and then adds 4 to the read pointer. Back-to-back reads return consecutive words.
- R6: Memory reads never change the write pointer, and memory writes never change the read pointer.
- R7: Registers 4 and 5 keep only bits 15..0 (offset) and bits 25..24 (length code L) of the written value. All other bits read back as zero.
- R8: Writing register 6 issues one peripheral write at the write-address offset. `perBe` has bits 0..L set and no others (L=3 means the full word). The offset does not change.
- R9: Reading register 7 issues one peripheral read at the read-address offset. It returns `perRdata` with the bytes above byte L forced to zero, and the offset does not change.
- R10: Writing register 3 or 7 produces no port access and changes no pointer. Reading register 2 or 6 returns zero, produces no port access and changes no pointer.
- R11: Pointer increments wrap modulo 2^32, so 0xFFFFFFFC advances to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Host request, held until acknowledged |
| hostWe | input | 1 | 1 = register write, 0 = register read |
| hostReg | input | 3 | Register index |
| hostWdata | input | 32 | Host write data |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read data, valid with hostAck, zero otherwise |
| memEn | output | 1 | SRAM access enable |
| memWe | output | 1 | SRAM write enable |
| memAddr | output | MEM_AW | SRAM word address |
| memWdata | output | 32 | SRAM write data |
| memRdata | input | 32 | SRAM read data, one cycle after memEn |
| perEn | output | 1 | Peripheral access enable |
| perWe | output | 1 | Peripheral write enable |
| perOff | output | PER_OFF_W | Peripheral register offset |
| perBe | output | 4 | Peripheral byte enables |
| perWdata | output | 32 | Peripheral write data |
| perRdata | input | 32 | Peripheral read data, one cycle after perEn |

## Verification
The bench sends bursts through the memory data registers and checks that they land on and return consecutive words. A design that sampled the pointer after the increment would be off by one word. A design with a shared pointer would skip words when reads and writes are interleaved.

Peripheral accesses are run with every length code. A wrong length decode shows up as a changed upper byte in the peripheral model or an unmasked read. A pointer wrongly incremented on a peripheral access shows up in the address readback. Writes to read-only data registers and reads of write-only data registers must leave no access at the ports. The top-of-range write exposes a pointer that saturates or carries wrongly instead of wrapping.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int DATA_W   = 32;
  localparam int STEP     = DATA_W / 8;
  localparam int LEN_LSB  = 24;

  localparam logic [2:0] REG_MRA = 3'd0;
  localparam logic [2:0] REG_MWA = 3'd1;
  localparam logic [2:0] REG_MWD = 3'd2;
  localparam logic [2:0] REG_MRD = 3'd3;
  localparam logic [2:0] REG_PRA = 3'd4;
  localparam logic [2:0] REG_PWA = 3'd5;
  localparam logic [2:0] REG_PWD = 3'd6;
  localparam logic [2:0] REG_PRD = 3'd7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       ldMemRa;
    logic       ldMemWa;
    logic       ldPerRa;
    logic       ldPerWa;
    logic       memRead;
    logic       memWrite;
    logic       perRead;
    logic       perWrite;
    logic       respEn;
    logic [2:0] respSel;
  } winStrobe_t;

  function automatic logic [3:0] lenToBe(input logic [1:0] len);
    logic [3:0] be;
    for (int i = 0; i < 4; i++) be[i] = (i <= int'(len));
    return be;
  endfunction

  function automatic logic [DATA_W-1:0] lenToMask(input logic [1:0] len);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = (i <= int'(len)) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/iwin_ctrl.sv
module iwin_ctrl
  import iwin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWe,
  input  logic [2:0] hostReg,
  output logic       hostAck,
  output winStrobe_t stb
);
  typedef enum logic {ST_IDLE, ST_RESP} state_e;
  state_e state;
  logic [2:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      regQ  <= 3'd0;
    end else begin
      case (state)
        ST_IDLE: if (hostReq) begin
          state <= ST_RESP;
          regQ  <= hostReg;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb     = '0;
    hostAck = 1'b0;
    if (state == ST_IDLE && hostReq) begin
      case (hostReg)
        REG_MRA: stb.ldMemRa  = hostWe;
        REG_MWA: stb.ldMemWa  = hostWe;
        REG_MWD: stb.memWrite = hostWe;
        REG_MRD: stb.memRead  = !hostWe;
        REG_PRA: stb.ldPerRa  = hostWe;
        REG_PWA: stb.ldPerWa  = hostWe;
        REG_PWD: stb.perWrite = hostWe;
        default: stb.perRead  = !hostWe;
      endcase
    end
    if (state == ST_RESP) begin
      stb.respEn  = 1'b1;
      stb.respSel = regQ;
      hostAck     = 1'b1;
    end
  end
endmodule

// File: rtl/iwin_dpath.sv
module iwin_dpath
  import iwin_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int PER_OFF_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           stb,
  input  logic [DATA_W-1:0]    hostWdata,
  output logic [DATA_W-1:0]    hostRdata,
  output logic                 memEn,
  output logic                 memWe,
  output logic [MEM_AW-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  output logic                 perEn,
  output logic                 perWe,
  output logic [PER_OFF_W-1:0] perOff,
  output logic [3:0]           perBe,
  output logic [DATA_W-1:0]    perWdata,
  input  logic [DATA_W-1:0]    perRdata,
  output logic [DATA_W-1:0]    memRdPtr,
  output logic [DATA_W-1:0]    memWrPtr
);
  localparam logic [DATA_W-1:0] OFF_KEEP  = DATA_W'((64'd1 << PER_OFF_W) - 64'd1);
  localparam logic [DATA_W-1:0] ADDR_KEEP = OFF_KEEP | (DATA_W'(3) << LEN_LSB);
  localparam logic [DATA_W-1:0] STEP_V    = DATA_W'(STEP);

  logic [DATA_W-1:0] perRdAddr, perWrAddr, perSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRdPtr  <= '0;
      memWrPtr  <= '0;
      perRdAddr <= '0;
      perWrAddr <= '0;
    end else begin
      if (stb.ldMemRa)      memRdPtr <= hostWdata;
      else if (stb.memRead) memRdPtr <= memRdPtr + STEP_V;
      if (stb.ldMemWa)       memWrPtr <= hostWdata;
      else if (stb.memWrite) memWrPtr <= memWrPtr + STEP_V;
      if (stb.ldPerRa) perRdAddr <= hostWdata & ADDR_KEEP;
      if (stb.ldPerWa) perWrAddr <= hostWdata & ADDR_KEEP;
    end
  end

  always_comb begin
    memEn    = stb.memRead | stb.memWrite;
    memWe    = stb.memWrite;
    memAddr  = stb.memWrite ? memWrPtr[MEM_AW+1:2] : memRdPtr[MEM_AW+1:2];
    memWdata = hostWdata;
    perEn    = stb.perRead | stb.perWrite;
    perWe    = stb.perWrite;
    perSel   = stb.perWrite ? perWrAddr : perRdAddr;
    perOff   = perSel[PER_OFF_W-1:0];
    perBe    = perEn ? lenToBe(perSel[LEN_LSB+1:LEN_LSB]) : 4'b0000;
    perWdata = hostWdata;
  end

  always_comb begin
    hostRdata = '0;
    if (stb.respEn) begin
      case (stb.respSel)
        REG_MRA: hostRdata = memRdPtr;
        REG_MWA: hostRdata = memWrPtr;
        REG_MRD: hostRdata = memRdata;
        REG_PRA: hostRdata = perRdAddr;
        REG_PWA: hostRdata = perWrAddr;
        REG_PRD: hostRdata = perRdata & lenToMask(perRdAddr[LEN_LSB+1:LEN_LSB]);
        default: hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/indirect_window.sv
module indirect_window
  import iwin_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int PER_OFF_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostReq,
  input  logic                 hostWe,
  input  logic [2:0]           hostReg,
  input  logic [31:0]          hostWdata,
  output logic                 hostAck,
  output logic [31:0]          hostRdata,
  output logic                 memEn,
  output logic                 memWe,
  output logic [MEM_AW-1:0]    memAddr,
  output logic [31:0]          memWdata,
  input  logic [31:0]          memRdata,
  output logic                 perEn,
  output logic                 perWe,
  output logic [PER_OFF_W-1:0] perOff,
  output logic [3:0]           perBe,
  output logic [31:0]          perWdata,
  input  logic [31:0]          perRdata
);
  winStrobe_t  stb;
  logic [31:0] memRdPtr, memWrPtr;

  iwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostReg(hostReg), .hostAck(hostAck), .stb(stb)
  );

  iwin_dpath #(.MEM_AW(MEM_AW), .PER_OFF_W(PER_OFF_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .perEn(perEn), .perWe(perWe), .perOff(perOff),
    .perBe(perBe), .perWdata(perWdata), .perRdata(perRdata),
    .memRdPtr(memRdPtr), .memWrPtr(memWrPtr)
  );
endmodule

// File: rtl/indirect_window_chk.sv
module indirect_window_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostAck,
  input logic        memEn,
  input logic        memWe,
  input logic        perEn,
  input logic [3:0]  perBe,
  input logic [31:0] memRdPtr,
  input logic [31:0] memWrPtr
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);
  p_ack_follows_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memEn || perEn) |=> hostAck);
  p_single_port_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && perEn));
  p_wptr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |=> (memWrPtr == $past(memWrPtr) + 32'd4));
  p_rptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> (memRdPtr == $past(memRdPtr) + 32'd4));
  p_rptr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |=> $stable(memRdPtr));
  p_wptr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> $stable(memWrPtr));
  p_be_contig_r8: assert property (@(posedge clk) disable iff (!rstN)
    perEn |-> (perBe == 4'h1 || perBe == 4'h3 || perBe == 4'h7 || perBe == 4'hF));
endmodule

bind indirect_window indirect_window_chk u_chk (
  .clk(clk), .rstN(rstN), .hostAck(hostAck), .memEn(memEn), .memWe(memWe),
  .perEn(perEn), .perBe(perBe), .memRdPtr(memRdPtr), .memWrPtr(memWrPtr)
);

// File: tb/indirect_window_bench.sv
`timescale 1ns/1ps
module indirect_window_bench;
  localparam int MEM_AW = 8;
  logic clk = 1'b0, rstN = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0;
  logic [2:0] hostReg = 3'd0;
  logic [31:0] hostWdata = '0;
  logic hostAck;
  logic [31:0] hostRdata;
  logic memEn, memWe, perEn, perWe;
  logic [MEM_AW-1:0] memAddr;
  logic [31:0] memWdata, perWdata;
  logic [31:0] memRdata = '0, perRdata = '0;
  logic [15:0] perOff;
  logic [3:0] perBe;

  int compared = 0, mismatched = 0;
  logic [31:0] sram [0:(1<<MEM_AW)-1];
  logic [31:0] perMem [0:15];
  int memHits = 0, perHits = 0;
  logic [3:0] lastBe = '0;
  logic [15:0] lastOff = '0;

  always #2.5 clk = ~clk;

  indirect_window #(.MEM_AW(MEM_AW), .PER_OFF_W(16)) u_indirect_window (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe), .hostReg(hostReg),
    .hostWdata(hostWdata), .hostAck(hostAck), .hostRdata(hostRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .perEn(perEn), .perWe(perWe), .perOff(perOff),
    .perBe(perBe), .perWdata(perWdata), .perRdata(perRdata)
  );

  always @(posedge clk) begin
    if (memEn) begin
      memHits <= memHits + 1;
      if (memWe) sram[memAddr] <= memWdata;
      memRdata <= sram[memAddr];
    end
    if (perEn) begin
      perHits <= perHits + 1;
      lastBe  <= perBe;
      lastOff <= perOff;
      if (perWe)
        for (int b = 0; b < 4; b++)
          if (perBe[b]) perMem[perOff[5:2]][b*8 +: 8] <= perWdata[b*8 +: 8];
      perRdata <= perMem[perOff[5:2]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One host transaction; R2 timing checked on every call.
  task automatic xfer(input logic we, input logic [2:0] r, input logic [31:0] wd,
                      output logic [31:0] rd);
    int waits = 0;
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostReg = r; hostWdata = wd;
    do begin
      @(negedge clk);
      waits++;
    end while (!hostAck && waits < 20);
    rd = hostRdata;
    hostReq = 1'b0;
    if (waits != 1) begin
      compared++; mismatched++;
      $display("FAIL R2: ack after %0d cycles, expected 1", waits);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [31:0] wd);
    logic [31:0] d;
    xfer(1'b1, r, wd, d);
  endtask

  task automatic rdchk(input string req, input logic [2:0] r, input logic [31:0] exp);
    logic [31:0] d;
    xfer(1'b0, r, 32'h0, d);
    check(req, d, exp);
  endtask

  task automatic test_reset();
    check("R1 ack", {31'b0, hostAck}, 32'h0);
    check("R1 en", {30'b0, memEn, perEn}, 32'h0);
    rdchk("R1 rptr", 3'd0, 32'h0);
    rdchk("R1 wptr", 3'd1, 32'h0);
    rdchk("R1 pra", 3'd4, 32'h0);
    rdchk("R1 pwa", 3'd5, 32'h0);
  endtask

  task automatic test_addr_regs();
    wr(3'd0, 32'hDEAD_BEE0); rdchk("R3 rptr", 3'd0, 32'hDEAD_BEE0);
    wr(3'd1, 32'h1234_5678); rdchk("R3 wptr", 3'd1, 32'h1234_5678);
    wr(3'd4, 32'hFFFF_1234); rdchk("R7 pra", 3'd4, 32'h0300_1234);
    wr(3'd5, 32'hFCFF_ABCD); rdchk("R7 pwa", 3'd5, 32'h0000_ABCD);
  endtask

  task automatic test_mem_write_burst();
    wr(3'd1, 32'h0000_0040);
    for (int i = 0; i < 4; i++) wr(3'd2, 32'hA000_0000 + i);
    for (int i = 0; i < 4; i++) check("R4 sram", sram[16+i], 32'hA000_0000 + i);
    rdchk("R4 wptr advanced", 3'd1, 32'h0000_0050);
  endtask

  task automatic test_mem_read_burst();
    for (int i = 0; i < 5; i++) sram[100+i] = 32'h5500_0000 + i;
    wr(3'd0, 32'd400);
    for (int i = 0; i < 5; i++) rdchk("R5 burst", 3'd3, 32'h5500_0000 + i);
    rdchk("R5 rptr advanced", 3'd0, 32'd420);
  endtask

  task automatic test_independent();
    for (int i = 0; i < 3; i++) sram[200+i] = 32'h7700_0000 + i;
    wr(3'd0, 32'd800);
    wr(3'd1, 32'd40);
    rdchk("R6 rd0", 3'd3, 32'h7700_0000);
    wr(3'd2, 32'hBB00_0001);
    rdchk("R6 rd1", 3'd3, 32'h7700_0001);
    wr(3'd2, 32'hBB00_0002);
    check("R6 wr0", sram[10], 32'hBB00_0001);
    check("R6 wr1", sram[11], 32'hBB00_0002);
    rdchk("R6 rptr", 3'd0, 32'd808);
    rdchk("R6 wptr", 3'd1, 32'd48);
  endtask

  task automatic test_per_write();
    wr(3'd5, 32'h0300_0010);
    wr(3'd6, 32'hFFFF_FFFF);
    check("R8 full be", {28'b0, lastBe}, 32'hF);
    for (int len = 0; len < 3; len++) begin
      logic [31:0] exp;
      wr(3'd5, 32'h0300_0010);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd5, (32'(len) << 24) | 32'h10);
      wr(3'd6, 32'h1122_3344);
      exp = 32'hFFFF_FFFF;
      for (int b = 0; b <= len; b++) exp[b*8 +: 8] = 8'h44 - 8'(b * 8'h11);
      check("R8 bytes", perMem[4], exp);
      check("R8 be", {28'b0, lastBe}, 32'((1 << (len + 1)) - 1));
      check("R8 off", {16'b0, lastOff}, 32'h10);
      rdchk("R8 offset held", 3'd5, (32'(len) << 24) | 32'h10);
    end
  endtask

  task automatic test_per_read();
    wr(3'd5, 32'h0300_0008);
    wr(3'd6, 32'hA1B2_C3D4);
    wr(3'd4, 32'h0100_0008);
    rdchk("R9 len1", 3'd7, 32'h0000_C3D4);
    rdchk("R9 len1 again", 3'd7, 32'h0000_C3D4);
    rdchk("R9 offset held", 3'd4, 32'h0100_0008);
    wr(3'd4, 32'h0000_0008); rdchk("R9 len0", 3'd7, 32'h0000_00D4);
    wr(3'd4, 32'h0200_0008); rdchk("R9 len2", 3'd7, 32'h00B2_C3D4);
    wr(3'd4, 32'h0300_0008); rdchk("R9 len3", 3'd7, 32'hA1B2_C3D4);
  endtask

  task automatic test_ignored();
    int m0, p0;
    wr(3'd0, 32'h0000_0100);
    wr(3'd1, 32'h0000_0200);
    @(negedge clk);
    m0 = memHits; p0 = perHits;
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rdchk("R10 read wdata reg", 3'd2, 32'h0);
    rdchk("R10 read pwdata reg", 3'd6, 32'h0);
    check("R10 no mem access", 32'(memHits - m0), 32'h0);
    check("R10 no per access", 32'(perHits - p0), 32'h0);
    rdchk("R10 rptr", 3'd0, 32'h0000_0100);
    rdchk("R10 wptr", 3'd1, 32'h0000_0200);
  endtask

  task automatic test_wrap();
    sram[255] = 32'h0F0F_0F0F;
    sram[0]   = 32'hF0F0_F0F0;
    wr(3'd0, 32'hFFFF_FFFC);
    rdchk("R11 top word", 3'd3, 32'h0F0F_0F0F);
    rdchk("R11 rptr wrapped", 3'd0, 32'h0);
    rdchk("R11 after wrap", 3'd3, 32'hF0F0_F0F0);
    wr(3'd1, 32'hFFFF_FFFC);
    wr(3'd2, 32'h1357_9BDF);
    check("R11 top write", sram[255], 32'h1357_9BDF);
    rdchk("R11 wptr wrapped", 3'd1, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) sram[i] = 32'(i) ^ 32'hC0DE_0000;
    for (int i = 0; i < 16; i++) perMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_addr_regs();
    test_mem_write_burst();
    test_mem_read_burst();
    test_independent();
    test_per_write();
    test_per_read();
    test_ignored();
    test_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule